// File: doc/BRIEF.md
# Windowed Event Counter Channel

This timer channel counts edges on an asynchronous event input, but only inside a time window. Two compare registers, start and end, are matched against an external free-running time-base bus. When the time base reaches the start value, the live event counter restarts from zero and counting opens. When it reaches the end value, counting closes, the count is copied into a holding register and a flag is raised.

Software reads the holding register for a result that stays coherent while the next window is being counted. The live counter is only reliable when read while the time base is outside the window. In continuous mode every start match opens a new window. In single-shot mode, after one start match the channel ignores further start matches until the start compare register is written again.

A small register port carries the configuration and the results. A control field picks rising, falling or both edges. Two force bits exist in the control word but do nothing in this counting mode.

Top module: `win_event_counter`

## Requirements
- R1: After reset the start compare, end compare, live counter, holding register, control word and flag all read 0. The window is closed and the start match is armed.
- R2: A write to address 0 loads the start compare value and a write to address 1 loads the end compare value. Both read back at the same addresses.
- R3: When the armed start compare equals timeBase, the next clock edge sets the live counter (address 2) to 0 and opens the window. An event that falls on that same edge is counted, so the counter becomes 1.
- R4: An end-compare match while the window is open, with no start match on the same edge, does three things on one edge. It closes the window, copies the live counter into the holding register (address 3) and sets the flag. An event on that edge is not counted.
- R5: With control bit 0 = 0 (continuous), every start match restarts the counter and reopens the window. While the window is closed the live counter does not change.
- R6: With control bit 0 = 1 (single-shot), a start match disarms the start comparator. Later start matches have no effect until address 0 is written again, and that write re-arms it.
- R7: The holding register changes only on an R4 capture edge.
- R8: Control bits [2:1] select which edges count: 00 none, 01 rising, 10 falling, 11 both. eventIn passes through a two-flop synchronizer, so a level change sampled at clock edge k is counted at edge k+2.
- R9: The live counter saturates at all ones instead of wrapping.
- R10: Writing 1 to status bit 0 (address 5) clears the flag. If a capture happens on the same edge, the flag stays set.
- R11: Control bits 3 and 4 (force start, force end) have no effect on the counter, the holding register or the flag, and they read back as 0.
- R12: flagOut always equals status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address: 0 start, 1 end, 2 counter, 3 hold, 4 control, 5 status |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| timeBase | input | DATA_W | Time-base bus |
| eventIn | input | 1 | Asynchronous event input |
| flagOut | output | 1 | Window-complete flag |

## Verification
Two functions can land on the same clock edge: an end-compare capture and a software flag clear, and a synchronized event and a window match at either end. The bench steers the time base so that a match falls exactly on the edge where a delayed event is counted, and it writes the status clear on the capture edge. It then judges the holding register, the live counter and the flag against hand-computed values and against a cycle model built from the requirements. Random traffic on compares, control writes, clears and events then makes these coincidences happen again and again.

// File: rtl/win_event_pkg.sv
package win_event_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CMP_START = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP_END   = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_LIVE_CNT  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_HOLD      = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_CONTROL   = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS    = 3'd5;

  localparam int unsigned CTRL_SINGLE_BIT = 0;
  localparam int unsigned CTRL_EDGE_LSB   = 1;
  localparam int unsigned CTRL_WR_W       = 3;
  localparam int unsigned STATUS_FLAG_BIT = 0;

  typedef enum logic [1:0] {
    EDGE_NONE    = 2'b00,
    EDGE_RISING  = 2'b01,
    EDGE_FALLING = 2'b10,
    EDGE_BOTH    = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic restart;
    logic firstEvt;
    logic countEn;
    logic capture;
  } win_strobe_t;

endpackage

// File: rtl/wec_ctrl.sv
module wec_ctrl
  import win_event_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [CTRL_WR_W-1:0]  ctrlWrData,
  input  logic                  matchStart,
  input  logic                  matchEnd,
  input  logic                  evtDet,
  output win_strobe_t           strb,
  output logic                  singleShot,
  output logic [1:0]            edgeSel,
  output logic                  flag,
  output logic                  winOpen,
  output logic                  armed
);

  logic startHit;
  logic wrStart;
  logic wrControl;
  logic flagClr;

  assign wrStart   = regWrEn && (regAddr == ADDR_CMP_START);
  assign wrControl = regWrEn && (regAddr == ADDR_CONTROL);
  assign flagClr   = regWrEn && (regAddr == ADDR_STATUS) && ctrlWrData[STATUS_FLAG_BIT];

  assign startHit = matchStart && armed;

  always_comb begin
    strb          = '0;
    strb.restart  = startHit;
    strb.firstEvt = startHit && evtDet;
    strb.capture  = !startHit && winOpen && matchEnd;
    strb.countEn  = !startHit && winOpen && !matchEnd && evtDet;
  end

  // control word; force bits are not stored
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      singleShot <= 1'b0;
      edgeSel    <= EDGE_NONE;
    end else if (wrControl) begin
      singleShot <= ctrlWrData[CTRL_SINGLE_BIT];
      edgeSel    <= ctrlWrData[CTRL_EDGE_LSB +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winOpen <= 1'b0;
    end else if (strb.restart) begin
      winOpen <= 1'b1;
    end else if (strb.capture) begin
      winOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (wrStart) begin
      armed <= 1'b1;
    end else if (startHit && singleShot) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (strb.capture) begin
      flag <= 1'b1;
    end else if (flagClr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/wec_datapath.sv
module wec_datapath
  import win_event_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic [DATA_W-1:0]     timeBase,
  input  logic                  eventIn,
  input  win_strobe_t           strb,
  input  logic                  singleShot,
  input  logic [1:0]            edgeSel,
  input  logic                  flag,
  output logic                  matchStart,
  output logic                  matchEnd,
  output logic                  evtDet,
  output logic [DATA_W-1:0]     cntVal,
  output logic [DATA_W-1:0]     holdVal,
  output logic [DATA_W-1:0]     rdData
);

  localparam logic [DATA_W-1:0] CNT_MAX = '1;
  localparam logic [DATA_W-1:0] CNT_ONE = DATA_W'(1);

  logic [DATA_W-1:0]      cmpStart;
  logic [DATA_W-1:0]      cmpEnd;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLvl;
  logic                   prevLvl;
  logic                   riseDet;
  logic                   fallDet;

  // compare registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpStart <= '0;
      cmpEnd   <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_CMP_START) cmpStart <= regWrData;
      if (regAddr == ADDR_CMP_END)   cmpEnd   <= regWrData;
    end
  end

  assign matchStart = (timeBase == cmpStart);
  assign matchEnd   = (timeBase == cmpEnd);

  // event synchronizer
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ[0] <= 1'b0;
        else        syncQ[0] <= eventIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) syncQ[i] <= 1'b0;
        else        syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign syncLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prevLvl <= 1'b0;
    else        prevLvl <= syncLvl;
  end

  assign riseDet = syncLvl && !prevLvl;
  assign fallDet = !syncLvl && prevLvl;
  assign evtDet  = (edgeSel[0] && riseDet) || (edgeSel[1] && fallDet);

  // live counter, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntVal <= '0;
    end else if (strb.restart) begin
      cntVal <= strb.firstEvt ? CNT_ONE : '0;
    end else if (strb.countEn && (cntVal != CNT_MAX)) begin
      cntVal <= cntVal + CNT_ONE;
    end
  end

  // holding register
  always_ff @(posedge clk) begin
    if (!rst_n)            holdVal <= '0;
    else if (strb.capture) holdVal <= cntVal;
  end

  always_comb begin
    case (regAddr)
      ADDR_CMP_START: rdData = cmpStart;
      ADDR_CMP_END:   rdData = cmpEnd;
      ADDR_LIVE_CNT:  rdData = cntVal;
      ADDR_HOLD:      rdData = holdVal;
      ADDR_CONTROL:   rdData = DATA_W'({edgeSel, singleShot});
      ADDR_STATUS:    rdData = DATA_W'(flag);
      default:        rdData = '0;
    endcase
  end

endmodule

// File: rtl/win_event_counter.sv
module win_event_counter
  import win_event_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [DATA_W-1:0]     timeBase,
  input  logic                  eventIn,
  output logic                  flagOut
);

  win_strobe_t       strb;
  logic              matchStart;
  logic              matchEnd;
  logic              evtDet;
  logic              singleShot;
  logic [1:0]        edgeSel;
  logic              flag;
  logic              winOpen;
  logic              armed;
  logic [DATA_W-1:0] cntVal;
  logic [DATA_W-1:0] holdVal;

  wec_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .ctrlWrData (regWrData[CTRL_WR_W-1:0]),
    .matchStart (matchStart),
    .matchEnd   (matchEnd),
    .evtDet     (evtDet),
    .strb       (strb),
    .singleShot (singleShot),
    .edgeSel    (edgeSel),
    .flag       (flag),
    .winOpen    (winOpen),
    .armed      (armed)
  );

  wec_datapath #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .timeBase   (timeBase),
    .eventIn    (eventIn),
    .strb       (strb),
    .singleShot (singleShot),
    .edgeSel    (edgeSel),
    .flag       (flag),
    .matchStart (matchStart),
    .matchEnd   (matchEnd),
    .evtDet     (evtDet),
    .cntVal     (cntVal),
    .holdVal    (holdVal),
    .rdData     (regRdData)
  );

  assign flagOut = flag;

endmodule

// File: rtl/wec_checker.sv
module wec_checker
  import win_event_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  regWrEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic                  statusClr,
  input logic                  flagOut,
  input logic                  singleShot,
  input logic                  armed,
  input logic                  winOpen,
  input logic                  restart,
  input logic                  capture,
  input logic [DATA_W-1:0]     cntVal,
  input logic [DATA_W-1:0]     holdVal
);

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  AST_HOLD_ONLY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(holdVal)); // R7

  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> flagOut); // R4

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == ADDR_STATUS && statusClr && !capture) |=> !flagOut); // R10

  AST_CLOSED_COUNT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!winOpen && !restart) |=> $stable(cntVal)); // R5

  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cntVal == ALL_ONES && !restart) |=> (cntVal == ALL_ONES)); // R9

  AST_SINGLE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (singleShot && restart && !(regWrEn && regAddr == ADDR_CMP_START)) |=> !armed); // R6

endmodule

bind win_event_counter wec_checker #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .statusClr  (regWrData[0]),
  .flagOut    (flagOut),
  .singleShot (singleShot),
  .armed      (armed),
  .winOpen    (winOpen),
  .restart    (strb.restart),
  .capture    (strb.capture),
  .cntVal     (cntVal),
  .holdVal    (holdVal)
);

// File: tb/win_event_counter_tb_top.sv
module win_event_counter_tb_top;
  import win_event_pkg::*;

  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          regWrEn;
  logic [2:0]    regAddr;
  logic [DW-1:0] regWrData;
  logic [DW-1:0] regRdData;
  logic [DW-1:0] timeBase;
  logic          eventIn;
  logic          flagOut;

  logic          sWrEn;
  logic [2:0]    sAddr;
  logic [3:0]    sWrData;
  logic [3:0]    sRd;
  logic [3:0]    sTime;
  logic          sEvt;
  logic          sFlag;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  win_event_counter #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timeBase(timeBase),
    .eventIn(eventIn), .flagOut(flagOut)
  );

  win_event_counter #(.DATA_W(4)) satDut_i (
    .clk(clk), .rst_n(rst_n), .regWrEn(sWrEn), .regAddr(sAddr),
    .regWrData(sWrData), .regRdData(sRd), .timeBase(sTime),
    .eventIn(sEvt), .flagOut(sFlag)
  );

  // reference model built from the requirements
  logic [DW-1:0] mA, mB, mCnt, mHold;
  logic          mSingle, mFlag, mOpen, mArmed, m1, m2, mPrev;
  logic [1:0]    mEdge;
  logic          ev, hitA, hitB;

  always @(posedge clk) begin
    if (!rst_n) begin
      mA = '0; mB = '0; mCnt = '0; mHold = '0;
      mSingle = 1'b0; mEdge = 2'b00; mFlag = 1'b0; mOpen = 1'b0; mArmed = 1'b1;
      m1 = 1'b0; m2 = 1'b0; mPrev = 1'b0;
    end else begin
      ev   = (mEdge[0] && m2 && !mPrev) || (mEdge[1] && !m2 && mPrev);
      hitA = mArmed && (timeBase == mA);
      hitB = !hitA && mOpen && (timeBase == mB);
      if (hitA) begin
        mCnt = ev ? DW'(1) : '0;
        mOpen = 1'b1;
      end else if (hitB) begin
        mHold = mCnt;
        mOpen = 1'b0;
      end else if (mOpen && ev && mCnt != '1) begin
        mCnt = mCnt + DW'(1);
      end
      if (hitB) mFlag = 1'b1;
      else if (regWrEn && regAddr == 3'd5 && regWrData[0]) mFlag = 1'b0;
      if (regWrEn && regAddr == 3'd0) mArmed = 1'b1;
      else if (hitA && mSingle) mArmed = 1'b0;
      if (regWrEn) begin
        if (regAddr == 3'd0) mA = regWrData;
        if (regAddr == 3'd1) mB = regWrData;
        if (regAddr == 3'd4) begin
          mSingle = regWrData[0];
          mEdge   = regWrData[2:1];
        end
      end
      mPrev = m2; m2 = m1; m1 = eventIn;
    end
  end

  function automatic logic [DW-1:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mA;
      3'd1: return mB;
      3'd2: return mCnt;
      3'd3: return mHold;
      3'd4: return DW'({mEdge, mSingle});
      3'd5: return DW'(mFlag);
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a)
      3'd0, 3'd1: return "R2";
      3'd2: return "R5";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nextCycle();
    @(posedge clk);
    @(negedge clk);
    check("R12", DW'(flagOut), DW'(mFlag));
    check(tagFor(regAddr), regRdData, expRead(regAddr));
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    nextCycle();
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [DW-1:0] exp, input string req);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    timeBase = '0; eventIn = 1'b0;
    sWrEn = 1'b0; sAddr = '0; sWrData = '0; sTime = '0; sEvt = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) rdChk(3'(a), '0, "R1");
    check("R1", DW'(flagOut), '0);
    rst_n = 1'b1;
    nextCycle();

    // continuous, both edges, window 10..20
    wr(3'd4, DW'(6));
    wr(3'd0, DW'(10));
    wr(3'd1, DW'(20));
    rdChk(3'd0, DW'(10), "R2");
    rdChk(3'd1, DW'(20), "R2");

    // event on the start-match edge counts as first
    eventIn = 1'b1;
    nextCycle(); nextCycle();
    timeBase = DW'(10);
    nextCycle();
    timeBase = '0;
    rdChk(3'd2, DW'(1), "R3");
    eventIn = 1'b0; repeat (4) nextCycle();
    eventIn = 1'b1; repeat (4) nextCycle();
    rdChk(3'd2, DW'(3), "R8");

    // event on the end-match edge is not counted
    eventIn = 1'b0;
    nextCycle(); nextCycle();
    timeBase = DW'(20);
    nextCycle();
    timeBase = '0;
    rdChk(3'd3, DW'(3), "R4");
    check("R4", DW'(flagOut), DW'(1));
    nextCycle(); nextCycle();
    rdChk(3'd2, DW'(3), "R4");

    // continuous restart
    timeBase = DW'(10);
    nextCycle();
    timeBase = '0;
    rdChk(3'd2, DW'(0), "R5");

    // clear colliding with capture: set wins
    regWrEn = 1'b1; regAddr = 3'd5; regWrData = DW'(1); timeBase = DW'(20);
    nextCycle();
    regWrEn = 1'b0; timeBase = '0;
    check("R10", DW'(flagOut), DW'(1));
    wr(3'd5, DW'(1));
    check("R10", DW'(flagOut), DW'(0));

    // force bits have no effect
    wr(3'd4, DW'(30));
    eventIn = 1'b1; repeat (4) nextCycle();
    rdChk(3'd4, DW'(6), "R11");
    rdChk(3'd2, DW'(0), "R11");
    rdChk(3'd3, DW'(0), "R11");
    check("R11", DW'(flagOut), DW'(0));

    // single shot, rising only
    eventIn = 1'b0;
    wr(3'd4, DW'(3));
    wr(3'd0, DW'(10));
    timeBase = DW'(10); nextCycle();
    timeBase = DW'(20); nextCycle();
    timeBase = '0;
    wr(3'd5, DW'(1));
    timeBase = DW'(10); nextCycle();
    timeBase = '0;
    eventIn = 1'b1; repeat (4) nextCycle();
    rdChk(3'd2, DW'(0), "R6");
    eventIn = 1'b0; repeat (4) nextCycle();
    wr(3'd0, DW'(10));
    timeBase = DW'(10); nextCycle();
    timeBase = '0;
    eventIn = 1'b1; repeat (4) nextCycle();
    rdChk(3'd2, DW'(1), "R6");
    eventIn = 1'b0; repeat (4) nextCycle();
    rdChk(3'd2, DW'(1), "R8");
    wr(3'd4, DW'(4));
    eventIn = 1'b1; repeat (4) nextCycle();
    eventIn = 1'b0; repeat (4) nextCycle();
    rdChk(3'd2, DW'(2), "R8");
    wr(3'd4, DW'(0));
    eventIn = 1'b1; repeat (4) nextCycle();
    rdChk(3'd2, DW'(2), "R8");

    // constrained random traffic
    for (int i = 0; i < 20000; i++) begin
      int r;
      timeBase = DW'(i % 64);
      if ($urandom % 3 == 0) eventIn = ~eventIn;
      regWrEn = 1'b0;
      regAddr = 3'($urandom % 8);
      r = int'($urandom % 100);
      if (r < 2) begin
        regWrEn = 1'b1; regAddr = 3'd0; regWrData = DW'($urandom % 64);
      end else if (r < 4) begin
        regWrEn = 1'b1; regAddr = 3'd1; regWrData = DW'($urandom % 64);
      end else if (r == 4) begin
        regWrEn = 1'b1; regAddr = 3'd4; regWrData = DW'($urandom % 32);
      end else if (r < 8) begin
        regWrEn = 1'b1; regAddr = 3'd5; regWrData = DW'($urandom % 2);
      end
      nextCycle();
    end
    regWrEn = 1'b0;

    // saturation on a narrow instance
    sWrEn = 1'b1; sAddr = 3'd4; sWrData = 4'd6; @(negedge clk);
    sAddr = 3'd0; sWrData = 4'd3; @(negedge clk);
    sAddr = 3'd1; sWrData = 4'd9; @(negedge clk);
    sWrEn = 1'b0; sTime = 4'd3; @(negedge clk);
    sTime = 4'd0;
    for (int k = 0; k < 20; k++) begin
      sEvt = ~sEvt;
      repeat (3) @(negedge clk);
    end
    sAddr = 3'd2; #1;
    check("R9", DW'(sRd), DW'(15));
    sTime = 4'd9; @(negedge clk);
    sTime = 4'd0;
    sAddr = 3'd3; #1;
    check("R9", DW'(sRd), DW'(15));
    check("R4", DW'(sFlag), DW'(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule